// File: doc/BRIEF.md
# Selective Replay Dependence Tracker

This block records, for every instruction-queue entry that has issued, which loads still awaiting their hit/miss verdict it depends on, directly or through other instructions. Each entry holds a small bit matrix: one column per load issue slot, one row per cycle between issue and verification. On issue, an entry's matrix is formed by ORing the current matrices of its source (parent) entries, shifted one row. If the entry is itself a load, the bit for its own slot is also placed in row 0. Every cycle without a new issue, each matrix moves down one row, and the oldest row falls off.

When the cache reports a miss, the miss slot is driven on the kill inputs. Every entry whose last row holds a set bit in that column is flagged on `replay_vec`, one bit per queue entry, so the scheduler can clear its ready state. Its matrix is cleared at the same time. Because the whole dependence history travels in the matrix, the full transitive set of dependents is flagged in a single cycle, and entries that do not depend on the missing load are left alone. A matrix that has drained to zero means the entry no longer depends on any unverified load, which is reported on `spec_vec`.

The miss verdict for a load issued at the edge ending cycle t is expected in cycle t+ROWS. Several issue lanes may write different entries in the same cycle.

Top module: `srr_tracker`

## Requirements
- R1: After synchronous reset, every matrix is zero, `spec_vec` is all zero, and `replay_vec` is all zero while no kill is driven.
- R2: A load issued on any lane with slot s into entry e makes `spec_vec[e]` high from the following cycle.
- R3: An issuing entry takes the OR of the matrices of all its valid sources, including sources whose loads sit in different slots. A kill on any of those slots at the parent's verification cycle flags the consumer too.
- R4: Dependence is transitive. A grandchild issued from a child of a load is flagged in the same cycle as the load and the child.
- R5: Entries with no path to the missing load are not flagged, and their matrices keep draining normally.
- R6: A kill names one slot (0 or 1). Entries whose only pending load bit lies in the other slot are not flagged.
- R7: A kill matches only the last row. A kill in the correct slot one cycle before a load's verification cycle flags nothing.
- R8: With no further issue, `spec_vec[e]` of a load issued at edge k stays high through ROWS edges and drops after edge k+ROWS.
- R9: An entry flagged on `replay_vec` has a zero matrix from the next cycle, so its `spec_vec` bit is low.
- R10: An entry issuing in the kill cycle, whose merged parent matrices hold the killed bit in the last row, is flagged in that same cycle and is stored with a zero matrix.
- R11: With `kill_vld` low, `replay_vec` stays zero whatever `kill_slot` and the matrices hold.
- R12: Two lanes may issue to two different entries in one cycle, each forming its own matrix independently. Two lanes must never target the same entry in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | ISSUE_W | Per-lane issue strobe |
| iss_idx | input | ISSUE_W x IDXW | Queue entry being issued on each lane |
| iss_src_vld | input | ISSUE_W x NSRC | Source operand has a tracked parent |
| iss_src_idx | input | ISSUE_W x NSRC x IDXW | Queue entry of each parent |
| iss_load | input | ISSUE_W | Issuing instruction is a load |
| iss_slot | input | ISSUE_W x SLW | Memory issue slot used by an issuing load |
| kill_vld | input | 1 | Miss reported this cycle |
| kill_slot | input | SLW | Slot of the missing load |
| replay_vec | output | NENT | Entries invalidated this cycle; bit e is queue entry e |
| spec_vec | output | NENT | Entries still depending on an unverified load |

## Verification
Several checks run on every cycle. A matrix that misses both an issue and a kill must move down exactly one row with an empty row 0. A flagged entry must hold a zero matrix on the next cycle, whether it was killed in place or caught while issuing. No replay may appear without a kill, and no entry may be written by two lanes at once. Only the directed scenarios can show the cycle alignment of the whole scheme. That covers which entries a kill flags across a dependence chain, the exclusion of independent entries, and the rejection of kills in the wrong slot or the wrong cycle. It also covers the exact cycle in which a drained entry stops being speculative.

// File: rtl/srr_pkg.sv
package srr_pkg;
    localparam int DEF_ENTRIES = 16;
    localparam int DEF_SLOTS   = 2;
    localparam int DEF_ROWS    = 4;
    localparam int DEF_LANES   = 2;
    localparam int DEF_SRCS    = 2;

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/srr_merge.sv
module srr_merge
    import srr_pkg::*;
#(
    parameter int NENT  = DEF_ENTRIES,
    parameter int SLOTS = DEF_SLOTS,
    parameter int ROWS  = DEF_ROWS,
    parameter int NSRC  = DEF_SRCS,
    localparam int MW   = SLOTS * ROWS,
    localparam int IDXW = idx_bits(NENT),
    localparam int SLW  = idx_bits(SLOTS)
) (
    input  logic                           vld,
    input  logic [NSRC-1:0]                src_vld,
    input  logic [NSRC-1:0][IDXW-1:0]      src_idx,
    input  logic                           is_load,
    input  logic [SLW-1:0]                 slot,
    input  logic                           kill_vld,
    input  logic [SLW-1:0]                 kill_slot,
    input  logic [NENT-1:0][MW-1:0]        mats,
    output logic [MW-1:0]                  nxt_mat,
    output logic                           hit
);
    logic [MW-1:0] merged;

    always_comb begin
        merged = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_vld[s]) merged = merged | mats[src_idx[s]];
        end
        hit = vld && kill_vld && merged[(ROWS-1)*SLOTS + int'(kill_slot)];
        nxt_mat = merged << SLOTS;
        if (is_load) nxt_mat[slot] = 1'b1;
        if (hit) nxt_mat = '0;
    end
endmodule

// File: rtl/srr_entry.sv
module srr_entry
    import srr_pkg::*;
#(
    parameter int SLOTS = DEF_SLOTS,
    parameter int ROWS  = DEF_ROWS,
    localparam int MW   = SLOTS * ROWS,
    localparam int SLW  = idx_bits(SLOTS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [MW-1:0]  wr_mat,
    input  logic           kill_vld,
    input  logic [SLW-1:0] kill_slot,
    output logic [MW-1:0]  mat,
    output logic           killed,
    output logic           spec
);
    assign killed = kill_vld && mat[(ROWS-1)*SLOTS + int'(kill_slot)];
    assign spec   = |mat;

    always_ff @(posedge clk) begin
        if (rst)          mat <= '0;
        else if (wr_en)   mat <= wr_mat;
        else if (killed)  mat <= '0;
        else              mat <= mat << SLOTS;
    end

    // R9: a killed entry that is not rewritten is empty next cycle
    assert_kill_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (killed && !wr_en) |=> (mat == '0));

    // R8: an undisturbed matrix moves down one row with row 0 empty
    assert_row_advance_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !killed) |=>
        ((mat[(ROWS-1)*SLOTS +: SLOTS] == $past(mat[(ROWS-2)*SLOTS +: SLOTS]))
         && (mat[SLOTS-1:0] == '0)));
endmodule

// File: rtl/srr_tracker.sv
module srr_tracker
    import srr_pkg::*;
#(
    parameter int NENT    = DEF_ENTRIES,
    parameter int SLOTS   = DEF_SLOTS,
    parameter int ROWS    = DEF_ROWS,
    parameter int ISSUE_W = DEF_LANES,
    parameter int NSRC    = DEF_SRCS,
    localparam int MW     = SLOTS * ROWS,
    localparam int IDXW   = idx_bits(NENT),
    localparam int SLW    = idx_bits(SLOTS)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [ISSUE_W-1:0]                     iss_vld,
    input  logic [ISSUE_W-1:0][IDXW-1:0]           iss_idx,
    input  logic [ISSUE_W-1:0][NSRC-1:0]           iss_src_vld,
    input  logic [ISSUE_W-1:0][NSRC-1:0][IDXW-1:0] iss_src_idx,
    input  logic [ISSUE_W-1:0]                     iss_load,
    input  logic [ISSUE_W-1:0][SLW-1:0]            iss_slot,
    input  logic                                   kill_vld,
    input  logic [SLW-1:0]                         kill_slot,
    output logic [NENT-1:0]                        replay_vec,
    output logic [NENT-1:0]                        spec_vec
);
    logic [NENT-1:0][MW-1:0]    mats;
    logic [ISSUE_W-1:0][MW-1:0] lane_mat;
    logic [ISSUE_W-1:0]         lane_hit;
    logic [NENT-1:0]            ent_kill;
    logic [NENT-1:0][ISSUE_W-1:0] lane_sel;

    for (genvar i = 0; i < ISSUE_W; i++) begin : g_lane
        srr_merge #(.NENT(NENT), .SLOTS(SLOTS), .ROWS(ROWS), .NSRC(NSRC)) u_merge (
            .vld(iss_vld[i]), .src_vld(iss_src_vld[i]), .src_idx(iss_src_idx[i]),
            .is_load(iss_load[i]), .slot(iss_slot[i]),
            .kill_vld(kill_vld), .kill_slot(kill_slot),
            .mats(mats), .nxt_mat(lane_mat[i]), .hit(lane_hit[i])
        );

        // R10: an entry caught while issuing holds an empty matrix next cycle
        assert_issue_kill_empty_R10: assert property (@(posedge clk) disable iff (rst)
            lane_hit[i] |=> (mats[$past(iss_idx[i])] == '0));
    end

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        logic          wr_en;
        logic [MW-1:0] wr_mat;
        logic          wr_hit;

        always_comb begin
            wr_mat = '0;
            wr_hit = 1'b0;
            for (int i = 0; i < ISSUE_W; i++) begin
                lane_sel[e][i] = iss_vld[i] && (int'(iss_idx[i]) == e);
                if (lane_sel[e][i]) begin
                    wr_mat = wr_mat | lane_mat[i];
                    wr_hit = wr_hit | lane_hit[i];
                end
            end
            wr_en = |lane_sel[e];
        end

        srr_entry #(.SLOTS(SLOTS), .ROWS(ROWS)) u_entry (
            .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mat(wr_mat),
            .kill_vld(kill_vld), .kill_slot(kill_slot),
            .mat(mats[e]), .killed(ent_kill[e]), .spec(spec_vec[e])
        );

        assign replay_vec[e] = ent_kill[e] | wr_hit;

        // R12: no two lanes write one entry in the same cycle
        assert_one_writer_R12: assert property (@(posedge clk) disable iff (rst)
            $countones(lane_sel[e]) <= 1);
    end

    // R11: replays appear only alongside a reported miss
    assert_replay_needs_kill_R11: assert property (@(posedge clk) disable iff (rst)
        (replay_vec != '0) |-> kill_vld);
endmodule

// File: tb/tb_srr_tracker.sv
module tb_srr_tracker;
    import srr_pkg::*;
    localparam int NENT = DEF_ENTRIES;
    localparam int SLOTS = DEF_SLOTS;
    localparam int ROWS = DEF_ROWS;
    localparam int IW = DEF_LANES;
    localparam int NSRC = DEF_SRCS;
    localparam int IDXW = idx_bits(NENT);
    localparam int SLW = idx_bits(SLOTS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [IW-1:0] iss_vld;
    logic [IW-1:0][IDXW-1:0] iss_idx;
    logic [IW-1:0][NSRC-1:0] iss_src_vld;
    logic [IW-1:0][NSRC-1:0][IDXW-1:0] iss_src_idx;
    logic [IW-1:0] iss_load;
    logic [IW-1:0][SLW-1:0] iss_slot;
    logic kill_vld;
    logic [SLW-1:0] kill_slot;
    logic [NENT-1:0] replay_vec, spec_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    srr_tracker dut (
        .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_idx(iss_idx),
        .iss_src_vld(iss_src_vld), .iss_src_idx(iss_src_idx),
        .iss_load(iss_load), .iss_slot(iss_slot),
        .kill_vld(kill_vld), .kill_slot(kill_slot),
        .replay_vec(replay_vec), .spec_vec(spec_vec)
    );

    task automatic chk(input string req, input logic [NENT-1:0] got, input logic [NENT-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        iss_vld = '0; iss_idx = '0; iss_src_vld = '0; iss_src_idx = '0;
        iss_load = '0; iss_slot = '0; kill_vld = 1'b0; kill_slot = '0;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic iss(input int ln, input int idx, input bit ld, input int sl,
                       input bit v0, input int s0, input bit v1, input int s1);
        iss_vld[ln] = 1'b1;
        iss_idx[ln] = IDXW'(idx);
        iss_load[ln] = ld;
        iss_slot[ln] = SLW'(sl);
        iss_src_vld[ln] = {v1, v0};
        iss_src_idx[ln][0] = IDXW'(s0);
        iss_src_idx[ln][1] = IDXW'(s1);
    endtask

    task automatic kill(input int sl);
        kill_vld = 1'b1;
        kill_slot = SLW'(sl);
    endtask

    task automatic drain();
        idle();
        tick(ROWS + 2);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 spec after reset", spec_vec, '0);
        chk("R1 replay after reset", replay_vec, '0);
    endtask

    // load e0 slot0 and independent load e5 slot1 on two lanes; chain e0->e1->e2, e5->e3
    task automatic t_chain();
        iss(0, 0, 1, 0, 0, 0, 0, 0);
        iss(1, 5, 1, 1, 0, 0, 0, 0);
        tick(1); idle(); #1;
        chk("R2 R12 spec after load issue", spec_vec, 16'h0021);
        iss(0, 1, 0, 0, 1, 0, 0, 0);
        tick(1); idle();
        iss(0, 2, 0, 0, 1, 1, 0, 0);
        iss(1, 3, 0, 0, 1, 5, 0, 0);
        tick(1); idle();
        tick(1); #1;
        chk("R5 spec before kill", spec_vec, 16'h002F);
        kill(0); #1;
        chk("R4 R5 transitive replay", replay_vec, 16'h0007);
        tick(1); idle(); #1;
        chk("R9 R8 spec after kill and drain", spec_vec, '0);
        drain();
    endtask

    task automatic t_wrong_slot();
        iss(0, 0, 1, 1, 0, 0, 0, 0);
        tick(1); idle();
        tick(ROWS - 1);
        kill(0); #1;
        chk("R6 other slot kill", replay_vec, '0);
        drain();
    endtask

    task automatic t_timing();
        iss(0, 4, 1, 0, 0, 0, 0, 0);
        tick(1); idle();
        tick(ROWS - 2);
        kill(0); #1;
        chk("R7 early kill", replay_vec, '0);
        tick(1); idle(); #1;
        chk("R8 spec at last row", spec_vec, 16'h0010);
        kill_slot = '0; #1;
        chk("R11 no kill strobe", replay_vec, '0);
        tick(1); #1;
        chk("R8 spec drained", spec_vec, '0);
        drain();
    endtask

    task automatic t_issue_in_kill();
        iss(0, 0, 1, 0, 0, 0, 0, 0);
        tick(1); idle();
        tick(ROWS - 1);
        kill(0);
        iss(1, 6, 0, 0, 1, 0, 0, 0); #1;
        chk("R10 issuing child flagged", replay_vec, 16'h0041);
        tick(1); idle(); #1;
        chk("R10 child not speculative", spec_vec, '0);
        drain();
    endtask

    task automatic t_two_parents();
        iss(0, 0, 1, 0, 0, 0, 0, 0);
        iss(1, 1, 1, 1, 0, 0, 0, 0);
        tick(1); idle();
        iss(0, 2, 0, 0, 1, 0, 1, 1);
        tick(1); idle();
        tick(ROWS - 2); #1;
        chk("R3 spec before kill", spec_vec, 16'h0007);
        kill(1); #1;
        chk("R3 merged slots flagged", replay_vec, 16'h0006);
        tick(1); idle(); #1;
        chk("R9 R8 spec after slot1 kill", spec_vec, '0);
        drain();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        idle();
        tick(3);
        rst = 1'b0;
        t_reset();
        t_chain();
        t_wrong_slot();
        t_timing();
        t_issue_in_kill();
        t_two_parents();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule